// File: doc/BRIEF.md
# Dual-Port Buffer Contention Arbiter

This block sits between a synchronous serial-side port and an asynchronous microprocessor port that share a set of 32-byte buffers. It does not hold the storage itself. Each timeslot, the serial side reads or writes one byte at a known address. The processor side presents a byte address together with a chip select and a data strobe, and these arrive at arbitrary times.

The arbiter watches a window made of the final fast-clock cycle of each timeslot. The system clock runs at twice the fast clock, so the window spans two system cycles. The input `win_a` marks the first half of the window and `win_b` marks the second half. The serial side uses only the second half. A collision is declared only when both ports name the same byte. When that happens the serial side wins, and the processor access is held off. In handshake mode the acknowledge is withheld. In wait-signal mode an active-low busy is raised. In synchronous mode no arbitration happens at all. A single-cycle `par_go` pulse marks the clock in which the pending parallel transfer is carried out.

Top module: `dpbuf_arbiter`

## Requirements
- R1: A hold-off occurs only while `par_addr` equals `ser_addr`. An access to a different byte is never held and raises no busy.
- R2: The serial side has priority. `par_go` never pulses on the clock after a cycle in which a held access collides.
- R3: The window is the pair of cycles marked by `win_a` (first half) and `win_b` (second half). An access that starts in the `win_b` cycle is held for that cycle only.
- R4: An access that starts before the window and whose strobe has dropped before `win_b` completes with no busy.
- R5: An access that starts before the window and is still active in the `win_b` cycle on the same byte drives `busy_n` low for one cycle.
- R6: An access that starts inside the window on the same byte raises busy on the next clock. Busy stays low until the window ends, and the transfer is performed afterwards.
- R7: Mode 2'b00 is handshake mode. `busy_n` stays high. `dtack_n` goes low on the clock after the `par_go` pulse and stays low until the strobe is released.
- R8: Mode 2'b10 (and 2'b11) is synchronous mode. No hold-off is applied, `busy_n` stays high and `dtack_n` stays high.
- R9: When the window ends, busy is released on the next clock. The held transfer's single `par_go` pulse occurs on that same clock, and exactly one pulse is produced per access.
- R10: The strobe is taken as `cs_n` and `ds_n` both low. It passes through a two-flop synchroniser, so an unhindered access pulses `par_go` after the third rising edge that follows strobe assertion.
- R11: While `rst` is high and after its release, with no access in progress, `par_go` is 0, `busy_n` is 1 and `dtack_n` is 1.

Mode 2'b01 selects wait-signal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the fast clock |
| rst | input | 1 | Synchronous reset, active high |
| win_a | input | 1 | First half of the window cycle |
| win_b | input | 1 | Second half of the window cycle (the serial access) |
| ser_addr | input | ADDR_W | Byte addressed by the serial side this timeslot |
| cs_n | input | 1 | Processor chip select, active low, asynchronous |
| ds_n | input | 1 | Processor data strobe, active low, asynchronous |
| par_addr | input | ADDR_W | Byte addressed by the processor |
| mode | input | 2 | 00 handshake, 01 wait-signal, 1x synchronous |
| par_go | output | 1 | One-cycle pulse: perform the parallel transfer |
| busy_n | output | 1 | Active-low busy, used in wait-signal mode |
| dtack_n | output | 1 | Active-low acknowledge, used in handshake mode |

## Verification
Strobes are started at every phase of interest relative to the window: well before it with a short hold, well before it with a hold that runs through `win_b`, on the `win_a` cycle, and on the `win_b` cycle. These patterns separate the normal-completion, late-overlap and started-inside cases by the busy length and by the phase of `par_go`. The same starting phases are then repeated with a mismatched address and in each of the three modes. This shows that address equality gates the hold-off, and that the mode alone picks busy, acknowledge stretching or no arbitration. Because the phase of the first `par_go` and of the acknowledge is recorded, the check also pins down the synchroniser latency and the one-clock release.

// File: rtl/dpbuf_arbiter.sv
module dpbuf_arbiter #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              win_a,
  input  logic              win_b,
  input  logic [ADDR_W-1:0] ser_addr,
  input  logic              cs_n,
  input  logic              ds_n,
  input  logic [ADDR_W-1:0] par_addr,
  input  logic [1:0]        mode,
  output logic              par_go,
  output logic              busy_n,
  output logic              dtack_n
);

  localparam logic [1:0] MODE_HS   = 2'd0;
  localparam logic [1:0] MODE_WAIT = 2'd1;

  logic [1:0] sync_q;
  logic       req_d;
  logic       in_win_q;
  logic       done_q;

  wire req      = sync_q[1];
  wire start    = req & ~req_d;
  wire window   = win_a | win_b;
  wire arb_on   = (mode == MODE_HS) | (mode == MODE_WAIT);
  wire same     = (par_addr == ser_addr);
  wire from_win = in_win_q | (start & window);
  wire hold     = req & same & arb_on & (win_b | (win_a & from_win));
  wire go       = req & ~hold & ~done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q   <= 2'b00;
      req_d    <= 1'b0;
      in_win_q <= 1'b0;
      done_q   <= 1'b0;
      par_go   <= 1'b0;
      busy_n   <= 1'b1;
      dtack_n  <= 1'b1;
    end else begin
      sync_q   <= {sync_q[0], ~cs_n & ~ds_n};
      req_d    <= req;
      in_win_q <= req & window & from_win;
      done_q   <= req & (done_q | go);
      par_go   <= go;
      busy_n   <= ~(hold & (mode == MODE_WAIT));
      dtack_n  <= ~((mode == MODE_HS) & req & done_q);
    end
  end

  AST_DIFF_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (par_addr != ser_addr) |=> busy_n);  // R1
  AST_SERIAL_FIRST: assert property (@(posedge clk) disable iff (rst)
    (req && same && arb_on && win_b) |=> !par_go);  // R2
  AST_HS_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HS) |=> busy_n);  // R7
  AST_ACK_AFTER_GO: assert property (@(posedge clk) disable iff (rst)
    $fell(dtack_n) |-> $past(par_go));  // R7
  AST_SYNC_FREE: assert property (@(posedge clk) disable iff (rst)
    mode[1] |=> (busy_n && dtack_n));  // R8
  AST_BUSY_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (!win_a && !win_b) |=> busy_n);  // R9
  AST_SINGLE_GO: assert property (@(posedge clk) disable iff (rst)
    par_go |=> !par_go);  // R9

endmodule

// File: tb/dpbuf_arbiter_tb.sv
module dpbuf_arbiter_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, ds_n = 1'b1;
  logic [4:0] ser_addr = 5'd9, par_addr = 5'd0;
  logic [1:0] mode = 2'd1;
  logic par_go, busy_n, dtack_n;
  int pc = 0;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) pc <= rst ? 0 : (pc + 1) % 8;

  wire win_a = (pc == 6);
  wire win_b = (pc == 7);

  dpbuf_arbiter #(.ADDR_W(5)) u_dut (
    .clk(clk), .rst(rst), .win_a(win_a), .win_b(win_b), .ser_addr(ser_addr),
    .cs_n(cs_n), .ds_n(ds_n), .par_addr(par_addr), .mode(mode),
    .par_go(par_go), .busy_n(busy_n), .dtack_n(dtack_n));

  typedef struct { int go; int busy; int dt; string tag; } exp_t;
  exp_t expq[$];
  bit mon_on = 1'b0, mon_close = 1'b0;
  int go_ph = 8, busy_cnt = 0, dt_ph = 8;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_close) begin
      exp_t e;
      e = expq.pop_front();
      check(go_ph == e.go, e.tag, "par_go phase", go_ph, e.go);
      check(busy_cnt == e.busy, e.tag, "busy cycles", busy_cnt, e.busy);
      check(dt_ph == e.dt, e.tag, "dtack phase", dt_ph, e.dt);
      go_ph = 8; busy_cnt = 0; dt_ph = 8;
    end else if (mon_on) begin
      if (par_go && go_ph == 8) go_ph = pc;
      if (!busy_n) busy_cnt++;
      if (!dtack_n && dt_ph == 8) dt_ph = pc;
    end
  end

  task automatic run_access(input logic [1:0] m, input logic [4:0] pa, input int q, input int len,
                            input int e_go, input int e_busy, input int e_dt, input string tag);
    exp_t e;
    e.go = e_go; e.busy = e_busy; e.dt = e_dt; e.tag = tag;
    expq.push_back(e);
    mode = m;
    par_addr = pa;
    do begin @(posedge clk); #1; end while (pc != q);
    cs_n = 1'b0; ds_n = 1'b0; mon_on = 1'b1;
    repeat (len) begin @(posedge clk); #1; end
    cs_n = 1'b1; ds_n = 1'b1;
    repeat (8) begin @(posedge clk); #1; end
    mon_on = 1'b0; mon_close = 1'b1;
    @(posedge clk); #1;
    mon_close = 1'b0;
  endtask

  initial begin
    #(100000 * 20);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(par_go == 1'b0, "R11", "reset par_go", par_go, 0);
    check(busy_n == 1'b1, "R11", "reset busy_n", busy_n, 1);
    check(dtack_n == 1'b1, "R11", "reset dtack_n", dtack_n, 1);
    // wait-signal mode (01), same byte
    run_access(2'd1, 5'd9, 0, 4, 3, 0, 8, "R4");
    run_access(2'd1, 5'd9, 0, 9, 3, 1, 8, "R5");
    run_access(2'd1, 5'd9, 4, 8, 1, 2, 8, "R2/R6/R9");
    run_access(2'd1, 5'd9, 5, 8, 1, 1, 8, "R3");
    // different byte
    run_access(2'd1, 5'd3, 4, 8, 7, 0, 8, "R1/R10");
    // synchronous mode (10)
    run_access(2'd2, 5'd9, 4, 8, 7, 0, 8, "R8");
    // handshake mode (00)
    run_access(2'd0, 5'd9, 4, 8, 1, 0, 2, "R7");
    run_access(2'd0, 5'd9, 0, 9, 3, 0, 4, "R7");
    run_access(2'd0, 5'd3, 4, 8, 7, 0, 0, "R10");
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule